// File: doc/BRIEF.md
# Serial port interrupt control unit

This block is the interrupt and control front end of a serial port that runs either asynchronously or with a shared clock. It holds the port's 8-bit control register and five status flags: transmit buffer empty, receive buffer full, overrun, framing error and parity error. The datapath reports each event as a one-cycle set pulse. The block turns the flags into three level-sensitive interrupt requests: transmit-empty, receive-full and receive-error.

The CPU reaches the block over a simple strobe bus with one select line. With the select low, the bus addresses the control register; with it high, the status register. A flag can be cleared only by a handshake. The CPU must first read the flag while it is 1, which arms that flag. A later write of 0 to the flag's bit then clears it. One receive enable bit gates both the receive-full and the receive-error requests. The remaining control bits are passed straight to the datapath.

Top module: `sport_irq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the control register, all flags and all interrupt outputs are 0, and a read of either register returns 0.
- R2: A write with `bus_sel_stat`=0 loads the control register. A read with `bus_sel_stat`=0 returns it on `bus_rdata` in the cycle after the `bus_rd` strobe. Bit 7 is the transmit interrupt enable and bit 6 is the receive interrupt enable. Bits 5, 4, 3 and 2 drive `ctl_tx_en`, `ctl_rx_en`, `ctl_mp_int_en` and `ctl_tx_end_int_en`, and bits 1:0 drive `ctl_clk_sel`.
- R3: While `standby_i` or `mod_standby_i` is high, the control register is forced to 0 and control writes are ignored. The status flags are not affected.
- R4: A one-cycle event pulse sets its flag. The status register, read with `bus_sel_stat`=1, has transmit-empty at bit 4, receive-full at bit 3, overrun at bit 2, framing at bit 1 and parity at bit 0. Bits 7:5 read 0.
- R5: A status write with the flag's bit at 0 clears the flag only if an earlier status read returned that flag as 1. A write of 0 without such a read leaves the flag at 1.
- R6: A status write with the flag's bit at 1 changes neither the flag nor its armed state.
- R7: If an event pulse and an armed clearing write reach the same flag in the same cycle, the flag stays 1. The arm is used up, so a further write of 0 without a new read leaves the flag at 1.
- R8: `irq_tx_empty` equals (transmit-empty flag AND control bit 7), registered one cycle. Clearing bit 7 drops the request on the next cycle and leaves the flag unchanged.
- R9: `irq_rx_full` equals (receive-full flag AND control bit 6), registered one cycle.
- R10: `irq_rx_err` equals ((overrun OR framing OR parity flag) AND control bit 6), registered one cycle.
- R11: A status read returning a flag as 0 does not arm that flag. If the flag is set later, a write of 0 with no new read leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Device standby; clears the control register |
| mod_standby_i | input | 1 | Module standby; clears the control register |
| bus_sel_stat | input | 1 | 0 selects the control register, 1 selects the status register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_tx_empty | input | 1 | Transmit buffer moved to shifter |
| ev_rx_full | input | 1 | Receive shifter moved to buffer |
| ev_overrun | input | 1 | Overrun detected |
| ev_frame_err | input | 1 | Framing error detected |
| ev_parity_err | input | 1 | Parity error detected |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |
| ctl_tx_en | output | 1 | Transmitter enable to datapath |
| ctl_rx_en | output | 1 | Receiver enable to datapath |
| ctl_mp_int_en | output | 1 | Multiprocessor interrupt enable to datapath |
| ctl_tx_end_int_en | output | 1 | Transmit-end interrupt enable to datapath |
| ctl_clk_sel | output | 2 | Clock source select to datapath |

## Verification
Two functions can meet in one cycle: the datapath setting a flag and the CPU clearing it with an armed write. The bench first arms the overrun flag with a status read. It then raises the overrun event in the same cycle as a status write of 0. It judges the outcome by reading the status back. The flag must still be 1, and a second write of 0 without a new read must also fail to clear it. A second overlap, a status read and a clearing write on a flag that is not armed, is judged the same way by read-back.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;
  localparam int REG_W   = 8;
  localparam int FLAG_N  = 5;
  // status bit positions, decoded by software
  localparam int F_TXE   = 4;
  localparam int F_RXF   = 3;
  localparam int F_ORE   = 2;
  localparam int F_FER   = 1;
  localparam int F_PER   = 0;
  localparam int ERR_HI  = F_ORE;
  localparam int ERR_LO  = F_PER;
  // control bit positions, decoded by software
  localparam int C_TXIE  = 7;
  localparam int C_RXIE  = 6;
  localparam int C_TXEN  = 5;
  localparam int C_RXEN  = 4;
  localparam int C_MPIE  = 3;
  localparam int C_TEND  = 2;
  localparam int C_CKHI  = 1;
  localparam int C_CKLO  = 0;
  localparam int PAD_W   = REG_W - FLAG_N;

  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [FLAG_N-1:0] flag_t;
endpackage

// File: rtl/sport_ctrl_reg.sv
module sport_ctrl_reg
  import sport_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stby,
  input  logic wr_en,
  input  reg_t wdata,
  output reg_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst || stby) ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= wdata;
  end
endmodule

// File: rtl/sport_flag_cell.sv
module sport_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic wbit,
  output logic flag_q
);
  logic arm_q;
  logic clr;

  always_comb clr = wr_stat && !wbit && arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_pulse) flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
      if (clr)                     arm_q <= 1'b0;
      else if (rd_stat && flag_q)  arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sport_irq_gen.sv
module sport_irq_gen
  import sport_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  flag_t flags,
  input  logic  tx_ie,
  input  logic  rx_ie,
  output logic  irq_txe,
  output logic  irq_rxf,
  output logic  irq_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_txe <= 1'b0;
      irq_rxf <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_txe <= flags[F_TXE] && tx_ie;
      irq_rxf <= flags[F_RXF] && rx_ie;
      irq_err <= (|flags[ERR_HI:ERR_LO]) && rx_ie;
    end
  end
endmodule

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
  import sport_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       standby_i,
  input  logic       mod_standby_i,
  input  logic       bus_sel_stat,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ev_tx_empty,
  input  logic       ev_rx_full,
  input  logic       ev_overrun,
  input  logic       ev_frame_err,
  input  logic       ev_parity_err,
  output logic       irq_tx_empty,
  output logic       irq_rx_full,
  output logic       irq_rx_err,
  output logic       ctl_tx_en,
  output logic       ctl_rx_en,
  output logic       ctl_mp_int_en,
  output logic       ctl_tx_end_int_en,
  output logic [1:0] ctl_clk_sel
);
  reg_t  ctrl_q;
  flag_t flag_q;
  flag_t ev_vec;
  logic  rd_stat, wr_stat, wr_ctrl;

  always_comb begin
    ev_vec         = '0;
    ev_vec[F_TXE]  = ev_tx_empty;
    ev_vec[F_RXF]  = ev_rx_full;
    ev_vec[F_ORE]  = ev_overrun;
    ev_vec[F_FER]  = ev_frame_err;
    ev_vec[F_PER]  = ev_parity_err;
    rd_stat        = bus_rd && bus_sel_stat;
    wr_stat        = bus_wr && bus_sel_stat;
    wr_ctrl        = bus_wr && !bus_sel_stat;
  end

  sport_ctrl_reg i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stby   (standby_i || mod_standby_i),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    sport_flag_cell i_cell (
      .clk       (clk),
      .rst       (rst),
      .set_pulse (ev_vec[g]),
      .rd_stat   (rd_stat),
      .wr_stat   (wr_stat),
      .wbit      (bus_wdata[g]),
      .flag_q    (flag_q[g])
    );
  end

  sport_irq_gen i_irq (
    .clk     (clk),
    .rst     (rst),
    .flags   (flag_q),
    .tx_ie   (ctrl_q[C_TXIE]),
    .rx_ie   (ctrl_q[C_RXIE]),
    .irq_txe (irq_tx_empty),
    .irq_rxf (irq_rx_full),
    .irq_err (irq_rx_err)
  );

  always_ff @(posedge clk) begin
    if (rst || !bus_rd)    bus_rdata <= '0;
    else if (bus_sel_stat) bus_rdata <= {{PAD_W{1'b0}}, flag_q};
    else                   bus_rdata <= ctrl_q;
  end

  always_comb begin
    ctl_tx_en         = ctrl_q[C_TXEN];
    ctl_rx_en         = ctrl_q[C_RXEN];
    ctl_mp_int_en     = ctrl_q[C_MPIE];
    ctl_tx_end_int_en = ctrl_q[C_TEND];
    ctl_clk_sel       = ctrl_q[C_CKHI:C_CKLO];
  end
endmodule

// File: rtl/sport_irq_ctrl_chk.sv
module sport_irq_ctrl_chk
  import sport_irq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       standby_i,
  input logic       mod_standby_i,
  input logic       bus_sel_stat,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input reg_t       ctrl_q,
  input flag_t      flag_q,
  input flag_t      ev_vec,
  input logic       irq_tx_empty,
  input logic       irq_rx_full,
  input logic       irq_rx_err
);
  // R3
  stby_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (standby_i || mod_standby_i) |=> (ctrl_q == '0));
  // R8
  tx_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q[F_TXE] && ctrl_q[C_TXIE]) |=> irq_tx_empty);
  // R8
  tx_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_TXIE] |=> !irq_tx_empty);
  // R9
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_RXIE] |=> !(irq_rx_full || irq_rx_err));
  // R10
  err_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((|flag_q[ERR_HI:ERR_LO]) && ctrl_q[C_RXIE]) |=> irq_rx_err);

  for (genvar g = 0; g < FLAG_N; g++) begin : g_fchk
    // R5
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[g]) |-> $past(bus_wr && bus_sel_stat && !bus_wdata[g]));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      ev_vec[g] |=> flag_q[g]);
  end
endmodule

bind sport_irq_ctrl sport_irq_ctrl_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .standby_i     (standby_i),
  .mod_standby_i (mod_standby_i),
  .bus_sel_stat  (bus_sel_stat),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .ctrl_q        (ctrl_q),
  .flag_q        (flag_q),
  .ev_vec        (ev_vec),
  .irq_tx_empty  (irq_tx_empty),
  .irq_rx_full   (irq_rx_full),
  .irq_rx_err    (irq_rx_err)
);

// File: tb/test_sport_irq_ctrl.sv
`timescale 1ns/1ps
module test_sport_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       standby_i = 0, mod_standby_i = 0;
  logic       bus_sel_stat = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       ev_tx_empty = 0, ev_rx_full = 0, ev_overrun = 0;
  logic       ev_frame_err = 0, ev_parity_err = 0;
  logic       irq_tx_empty, irq_rx_full, irq_rx_err;
  logic       ctl_tx_en, ctl_rx_en, ctl_mp_int_en, ctl_tx_end_int_en;
  logic [1:0] ctl_clk_sel;

  int total = 0;
  int bad   = 0;
  logic rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sport_irq_ctrl i_sport_irq_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("read without expectation", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    bus_sel_stat = sel; bus_wdata = d; bus_wr = 1;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] e, input string tag);
    bus_sel_stat = sel; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    tick();
    bus_rd = 0;
  endtask

  task automatic pulse(input int which);
    case (which)
      4: ev_tx_empty   = 1;
      3: ev_rx_full    = 1;
      2: ev_overrun    = 1;
      1: ev_frame_err  = 1;
      default: ev_parity_err = 1;
    endcase
    tick();
    {ev_tx_empty, ev_rx_full, ev_overrun, ev_frame_err, ev_parity_err} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 irq_tx in reset", irq_tx_empty, 0);
    rst = 0;
    tick();
    chk("R1 irq_rx_full", irq_rx_full, 0);
    chk("R1 irq_rx_err", irq_rx_err, 0);
    chk("R1 ctl_clk_sel", ctl_clk_sel, 0);
    rd(0, 8'h00, "R1 ctrl after reset");
    rd(1, 8'h00, "R1 stat after reset");

    wr(0, 8'h3F);
    rd(0, 8'h3F, "R2 ctrl readback");
    chk("R2 ctl_tx_en", ctl_tx_en, 1);
    chk("R2 ctl_rx_en", ctl_rx_en, 1);
    chk("R2 ctl_mp_int_en", ctl_mp_int_en, 1);
    chk("R2 ctl_tx_end_int_en", ctl_tx_end_int_en, 1);
    chk("R2 ctl_clk_sel", ctl_clk_sel, 3);
    wr(0, 8'hA5);
    rd(0, 8'hA5, "R2 ctrl readback 2");

    wr(0, 8'hFF);
    standby_i = 1; tick(); standby_i = 0;
    rd(0, 8'h00, "R3 standby clears ctrl");
    mod_standby_i = 1;
    wr(0, 8'h55);
    rd(0, 8'h00, "R3 write ignored in module standby");
    mod_standby_i = 0;

    pulse(4);
    rd(1, 8'h10, "R4 tx-empty flag at bit 4");
    tick();
    chk("R8 irq_tx off with enable 0", irq_tx_empty, 0);
    wr(0, 8'h80); tick();
    chk("R8 irq_tx on", irq_tx_empty, 1);
    wr(0, 8'h00); tick();
    chk("R8 irq_tx off after enable cleared", irq_tx_empty, 0);
    rd(1, 8'h10, "R8 flag kept after enable cleared");

    wr(1, 8'hFF);
    rd(1, 8'h10, "R6 write of 1 no effect");
    wr(1, 8'h00);
    rd(1, 8'h00, "R5 armed write of 0 clears");
    pulse(4);
    wr(1, 8'h00);
    rd(1, 8'h10, "R5 write 0 without read keeps flag");
    wr(1, 8'h00);
    rd(1, 8'h00, "R5 clear after read");

    rd(1, 8'h00, "R11 read while clear");
    pulse(3);
    wr(1, 8'h00);
    rd(1, 8'h08, "R11 read-as-0 does not arm");
    wr(1, 8'h00);
    rd(1, 8'h00, "R11 cleared after proper read");

    pulse(2);
    rd(1, 8'h04, "R7 overrun at bit 2");
    bus_sel_stat = 1; bus_wdata = 8'h00; bus_wr = 1; ev_overrun = 1;
    tick();
    bus_wr = 0; ev_overrun = 0;
    wr(1, 8'h00);
    rd(1, 8'h04, "R7 set wins and arm consumed");
    wr(1, 8'h00);
    rd(1, 8'h00, "R7 cleared after new read");

    wr(0, 8'h40);
    pulse(3); tick();
    chk("R9 irq_rx_full on", irq_rx_full, 1);
    chk("R10 irq_rx_err off", irq_rx_err, 0);
    chk("R8 irq_tx off", irq_tx_empty, 0);
    pulse(0); tick();
    chk("R10 irq_rx_err parity", irq_rx_err, 1);
    wr(0, 8'h00); tick();
    chk("R9 irq_rx_full gated", irq_rx_full, 0);
    chk("R10 irq_rx_err gated", irq_rx_err, 0);
    wr(0, 8'h40); tick();
    chk("R10 irq_rx_err back", irq_rx_err, 1);
    rd(1, 8'h09, "R4 rx-full and parity bits");
    wr(1, 8'h00); tick();
    chk("R9 irq_rx_full after clear", irq_rx_full, 0);
    chk("R10 irq_rx_err after clear", irq_rx_err, 0);
    pulse(1); tick();
    chk("R10 irq_rx_err framing", irq_rx_err, 1);
    rd(1, 8'h02, "R4 framing at bit 1");
    wr(1, 8'h00); tick();
    chk("R10 irq_rx_err framing cleared", irq_rx_err, 0);

    repeat (2) tick();
    chk("scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule